// File: doc/BRIEF.md
# I2C Target Protocol Controller with High-Speed Entry and General-Call Reset

This block is the protocol core of a two-wire serial target that sits in front of a register bank. It resynchronises the clock and data lines to the system clock and finds bus conditions from edges of the synchronised samples. A START or repeated START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. It shifts each byte in or out MSB first and decides, byte by byte, whether to pull the data line low in the acknowledge slot.

Three kinds of first byte are handled besides the target's own 7-bit address (a parameter). A byte of the form 00001xxx is the high-speed master code. It is never acknowledged, and it raises a high-speed flag that drives the filter-select output. The flag survives repeated STARTs and drops at the next STOP. The all-zero byte is the general call, which is always acknowledged. After it, only the reset command byte 0x06 is acknowledged, and that byte fires a one-cycle reset pulse that the register bank treats like power-up.

Downstream, written bytes appear as a one-cycle strobe with the byte value. Read bytes are requested with a one-cycle request and taken from a data input. A start flag marks an accepted own-address byte, a read/write level gives its direction, and a stop flag marks each STOP. An address that matches nothing is not acknowledged, and the block stays silent until the next START or STOP.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset the data line is released (sda_pull_o = 0), hs_filter_o = 0, and no strobe or pulse output is high.
- R2: A first byte after START or repeated START whose bits [7:3] are 00001 is taken as the high-speed master code for any value of bits [2:0]. It is never acknowledged: SDA stays released in its acknowledge slot.
- R3: The master code sets hs_filter_o. The flag stays set across any number of repeated STARTs and is cleared by the next STOP.
- R4: A first byte of 0x00 (general call) is always acknowledged.
- R5: After a general call, a data byte of 0x06 is acknowledged and produces exactly one gc_reset_o pulse that lasts one clock cycle.
- R6: After a general call, any data byte other than 0x06 is not acknowledged. It produces no gc_reset_o pulse and no rx_valid_o strobe, and later bytes up to the next START or STOP are ignored as well.
- R7: A first byte whose bits [7:1] equal TARGET_ADDR is acknowledged. xfer_start_o pulses once, and rx_is_read_o takes the value of bit [0] (1 = read).
- R8: A first byte that matches none of the above is not acknowledged. The following bytes up to the next START or STOP get no acknowledge and no strobe.
- R9: In a write to the own address, each data byte is received MSB first and acknowledged, and it is delivered as a one-cycle rx_valid_o with the byte on rx_data_o.
- R10: In a read, tx_req_o requests each byte and tx_data_i is shifted out MSB first. Transmission continues after a controller ACK (SDA low). After a NACK (SDA high) the target releases SDA.
- R11: Every STOP produces a one-cycle xfer_stop_o pulse and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (wired-AND bus value) |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| hs_filter_o | output | 1 | High-speed filter select, follows the high-speed flag |
| gc_reset_o | output | 1 | One-cycle full reset pulse for the register bank |
| rx_valid_o | output | 1 | One-cycle strobe for a received data byte |
| rx_data_o | output | 8 | Received data byte |
| rx_is_read_o | output | 1 | Direction of the current transfer, 1 = read |
| xfer_start_o | output | 1 | One-cycle pulse when the own address is accepted |
| xfer_stop_o | output | 1 | One-cycle pulse on STOP |
| tx_req_o | output | 1 | One-cycle request for the next byte to transmit |
| tx_data_i | input | 8 | Byte to transmit, valid from the cycle after tx_req_o |

## Verification
The bench sends master codes with different low bits and then repeated STARTs before the STOP. A design that acknowledged the code, required exact low bits, or dropped the flag at a repeated START would show a pulled acknowledge slot or a low filter select. It sends general calls followed by 0x06, by another byte and by 0x06 after another byte. A design that acknowledged every general-call byte, or that let a wrong command followed by 0x06 reset the bank, shows up as a pulse count or an acknowledge that differs from the expected one. A foreign address followed by data exercises the silent-until-STOP rule. A two-byte read that ends in a NACK exposes a target that keeps driving the line or shifts bits in the wrong order.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;

    localparam logic [7:0] GCALL_BYTE     = 8'h00;
    localparam logic [7:0] GCALL_RST_CMD  = 8'h06;
    localparam logic [4:0] HS_CODE_PREFIX = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        NXT_WRITE,
        NXT_READ,
        NXT_GCALL
    } ack_next_e;

    typedef enum logic [2:0] {
        ADR_OWN_WR,
        ADR_OWN_RD,
        ADR_GCALL,
        ADR_HS_CODE,
        ADR_OTHER
    } addr_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic addr_kind_e classify_first(input logic [7:0] b, input logic [6:0] own);
        if (b == GCALL_BYTE)
            return ADR_GCALL;
        else if (b[7:3] == HS_CODE_PREFIX)
            return ADR_HS_CODE;
        else if (b[7:1] == own)
            return b[0] ? ADR_OWN_RD : ADR_OWN_WR;
        else
            return ADR_OTHER;
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_s, sda_s, scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_comb begin
        evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.sda      = sda_s;
    end

    // R11: a STOP event needs the data line to have been low one sample earlier
    stop_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o.stop |-> ($past(sda_s) == 1'b0));

endmodule

// File: rtl/i2c_hs_tracker.sv
module i2c_hs_tracker (
    input  logic clk,
    input  logic rst,
    input  logic hs_code_i,
    input  logic stop_i,
    output logic hs_o
);

    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst)
            hs_q <= 1'b0;
        else if (stop_i)
            hs_q <= 1'b0;
        else if (hs_code_i)
            hs_q <= 1'b1;
    end

    assign hs_o = hs_q;

    // R3
    hs_clear_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !hs_o);

    // R3
    hs_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_o) |-> $past(stop_i));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt_i,
    input  logic [7:0] tx_data_i,
    output logic       sda_pull_o,
    output logic       hs_code_o,
    output logic       gc_reset_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_is_read_o,
    output logic       xfer_start_o,
    output logic       xfer_stop_o,
    output logic       tx_req_o
);

    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);

    tgt_state_e       state_q;
    ack_next_e        next_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [7:0]       shreg_q;
    logic             gcall_q;
    logic             mack_q;
    logic             pull_q;
    addr_kind_e       kind;

    assign kind = classify_first(shreg_q, TARGET_ADDR);

    always_ff @(posedge clk) begin
        rx_valid_o   <= 1'b0;
        xfer_start_o <= 1'b0;
        xfer_stop_o  <= 1'b0;
        tx_req_o     <= 1'b0;
        gc_reset_o   <= 1'b0;
        hs_code_o    <= 1'b0;
        if (rst) begin
            state_q      <= ST_IDLE;
            next_q       <= NXT_WRITE;
            bit_cnt_q    <= '0;
            shreg_q      <= '0;
            gcall_q      <= 1'b0;
            mack_q       <= 1'b0;
            pull_q       <= 1'b0;
            rx_data_o    <= '0;
            rx_is_read_o <= 1'b0;
        end else if (evt_i.stop) begin
            state_q     <= ST_IDLE;
            pull_q      <= 1'b0;
            gcall_q     <= 1'b0;
            xfer_stop_o <= 1'b1;
        end else if (evt_i.start) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
            pull_q    <= 1'b0;
            gcall_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WDATA: begin
                    if (evt_i.scl_rise && bit_cnt_q != FULL_CNT) begin
                        shreg_q   <= {shreg_q[6:0], evt_i.sda};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (evt_i.scl_fall && bit_cnt_q == FULL_CNT) begin
                        if (state_q == ST_ADDR) begin
                            unique case (kind)
                                ADR_HS_CODE: begin
                                    hs_code_o <= 1'b1;
                                    state_q   <= ST_IGNORE;
                                end
                                ADR_GCALL: begin
                                    pull_q  <= 1'b1;
                                    gcall_q <= 1'b1;
                                    next_q  <= NXT_GCALL;
                                    state_q <= ST_ACK;
                                end
                                ADR_OWN_WR: begin
                                    pull_q       <= 1'b1;
                                    next_q       <= NXT_WRITE;
                                    rx_is_read_o <= 1'b0;
                                    xfer_start_o <= 1'b1;
                                    state_q      <= ST_ACK;
                                end
                                ADR_OWN_RD: begin
                                    pull_q       <= 1'b1;
                                    next_q       <= NXT_READ;
                                    rx_is_read_o <= 1'b1;
                                    xfer_start_o <= 1'b1;
                                    tx_req_o     <= 1'b1;
                                    state_q      <= ST_ACK;
                                end
                                default: state_q <= ST_IGNORE;
                            endcase
                        end else if (gcall_q) begin
                            if (shreg_q == GCALL_RST_CMD) begin
                                pull_q     <= 1'b1;
                                gc_reset_o <= 1'b1;
                                next_q     <= NXT_GCALL;
                                state_q    <= ST_ACK;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end else begin
                            pull_q     <= 1'b1;
                            rx_valid_o <= 1'b1;
                            rx_data_o  <= shreg_q;
                            next_q     <= NXT_WRITE;
                            state_q    <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt_i.scl_fall) begin
                        bit_cnt_q <= '0;
                        if (next_q == NXT_READ) begin
                            shreg_q <= tx_data_i;
                            pull_q  <= ~tx_data_i[7];
                            state_q <= ST_RDATA;
                        end else begin
                            pull_q  <= 1'b0;
                            state_q <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (evt_i.scl_rise && bit_cnt_q != FULL_CNT) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (evt_i.scl_fall) begin
                        if (bit_cnt_q == FULL_CNT) begin
                            pull_q  <= 1'b0;
                            state_q <= ST_RACK;
                        end else begin
                            shreg_q <= {shreg_q[6:0], 1'b0};
                            pull_q  <= ~shreg_q[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (evt_i.scl_rise) begin
                        mack_q   <= ~evt_i.sda;
                        tx_req_o <= ~evt_i.sda;
                    end else if (evt_i.scl_fall) begin
                        bit_cnt_q <= '0;
                        if (mack_q) begin
                            shreg_q <= tx_data_i;
                            pull_q  <= ~tx_data_i[7];
                            state_q <= ST_RDATA;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = pull_q;

    // R2
    hs_code_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        hs_code_o |-> !sda_pull_o);

    // R5
    gc_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        gc_reset_o |=> !gc_reset_o);

    // R7
    own_addr_acked_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start_o |-> (sda_pull_o && !rx_valid_o));

    // R8
    silent_when_ignoring_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IGNORE && $past(state_q) == ST_IGNORE) |-> !sda_pull_o);

    // R11
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.stop |=> (xfer_stop_o && !sda_pull_o));

endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       hs_filter_o,
    output logic       gc_reset_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_is_read_o,
    output logic       xfer_start_o,
    output logic       xfer_stop_o,
    output logic       tx_req_o,
    input  logic [7:0] tx_data_i
);

    bus_evt_t evt;
    logic     hs_code;

    i2c_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_target_fsm #(
        .TARGET_ADDR(TARGET_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .tx_data_i    (tx_data_i),
        .sda_pull_o   (sda_pull_o),
        .hs_code_o    (hs_code),
        .gc_reset_o   (gc_reset_o),
        .rx_valid_o   (rx_valid_o),
        .rx_data_o    (rx_data_o),
        .rx_is_read_o (rx_is_read_o),
        .xfer_start_o (xfer_start_o),
        .xfer_stop_o  (xfer_stop_o),
        .tx_req_o     (tx_req_o)
    );

    i2c_hs_tracker u_hs (
        .clk       (clk),
        .rst       (rst),
        .hs_code_i (hs_code),
        .stop_i    (evt.stop),
        .hs_o      (hs_filter_o)
    );

endmodule

// File: tb/i2c_hs_target_bench.sv
`timescale 1ns/1ps
module i2c_hs_target_bench;

    localparam logic [6:0] OWN = 7'h2C;
    localparam int QTR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, hs_filter, gc_reset, rx_valid, rx_is_read, xfer_start, xfer_stop, tx_req;
    logic [7:0] rx_data;
    logic [7:0] tx_data = 8'h00;
    logic sda_line;

    int n_checks = 0;
    int n_errors = 0;
    int gc_count = 0;
    int start_count = 0;
    int stop_count = 0;
    logic [7:0] exp_q[$];
    logic [7:0] tx_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_hs_target #(.TARGET_ADDR(OWN)) u_i2c_hs_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .hs_filter_o(hs_filter), .gc_reset_o(gc_reset),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_is_read_o(rx_is_read),
        .xfer_start_o(xfer_start), .xfer_stop_o(xfer_stop), .tx_req_o(tx_req),
        .tx_data_i(tx_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for written bytes (R9), pulse counters, read data supply (R10)
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected rx strobe", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R9 rx byte", rx_data, e);
                end
            end
            if (gc_reset) gc_count++;
            if (xfer_start) start_count++;
            if (xfer_stop) stop_count++;
            if (tx_req && tx_q.size() != 0) tx_data <= tx_q.pop_front();
        end
    end

    task automatic qwait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        acked = (sda_line == 1'b0);
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl_m = 1'b1; qwait();
            b[i] = sda_line;
            qwait();
            scl_m = 1'b0;
        end
        qwait();
        sda_m = give_ack ? 1'b0 : 1'b1; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
        check(hs_filter == 1'b0, "R1 hs low", hs_filter, 0);
        check(!gc_reset && !rx_valid && !xfer_start && !xfer_stop && !tx_req, "R1 pulses low", 1, 0);
        qwait();

        // R7 / R9 write to own address
        bus_start();
        put_byte({OWN, 1'b0}, ack);
        check(ack, "R7 own write address ack", ack, 1);
        check(rx_is_read == 1'b0, "R7 write direction", rx_is_read, 0);
        exp_q.push_back(8'hA5);
        put_byte(8'hA5, ack);
        check(ack, "R9 data ack", ack, 1);
        exp_q.push_back(8'h3C);
        put_byte(8'h3C, ack);
        check(ack, "R9 data ack", ack, 1);
        bus_stop(); qwait();
        check(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 0);
        check(start_count == 1, "R7 start pulse count", start_count, 1);
        check(stop_count == 1, "R11 stop pulse count", stop_count, 1);
        check(sda_line == 1'b1, "R11 line released", sda_line, 1);

        // R8 foreign address
        bus_start();
        put_byte({7'h13, 1'b0}, ack);
        check(!ack, "R8 foreign address nack", ack, 0);
        put_byte(8'h55, ack);
        check(!ack, "R8 following byte ignored", ack, 0);
        bus_stop(); qwait();
        check(start_count == 1, "R8 no start pulse", start_count, 1);

        // R2 / R3 master code with repeated STARTs
        bus_start();
        put_byte(8'h0B, ack);
        check(!ack, "R2 master code not acked", ack, 0);
        check(hs_filter == 1'b1, "R3 hs set", hs_filter, 1);
        bus_start();
        check(hs_filter == 1'b1, "R3 hs kept over Sr", hs_filter, 1);
        put_byte({OWN, 1'b0}, ack);
        check(ack, "R7 address after Sr ack", ack, 1);
        exp_q.push_back(8'h77);
        put_byte(8'h77, ack);
        check(ack, "R9 hs data ack", ack, 1);
        bus_start();
        put_byte({OWN, 1'b0}, ack);
        check(hs_filter == 1'b1, "R3 hs kept over second Sr", hs_filter, 1);
        bus_stop(); qwait();
        check(hs_filter == 1'b0, "R3 hs cleared by STOP", hs_filter, 0);

        // R2 other low bits
        bus_start();
        put_byte(8'h0F, ack);
        check(!ack, "R2 code 0x0F not acked", ack, 0);
        check(hs_filter == 1'b1, "R2 code 0x0F sets hs", hs_filter, 1);
        bus_stop(); qwait();
        check(hs_filter == 1'b0, "R3 hs cleared", hs_filter, 0);
        bus_start();
        put_byte(8'h08, ack);
        check(!ack && hs_filter, "R2 code 0x08 sets hs without ack", {ack, hs_filter}, 1);
        bus_stop(); qwait();

        // R4 / R5 general call reset
        bus_start();
        put_byte(8'h00, ack);
        check(ack, "R4 general call acked", ack, 1);
        put_byte(8'h06, ack);
        check(ack, "R5 reset command acked", ack, 1);
        bus_stop(); qwait();
        check(gc_count == 1, "R5 one reset pulse", gc_count, 1);

        // R6 other general call data
        bus_start();
        put_byte(8'h00, ack);
        check(ack, "R4 general call acked again", ack, 1);
        put_byte(8'h05, ack);
        check(!ack, "R6 other command nacked", ack, 0);
        put_byte(8'h06, ack);
        check(!ack, "R6 later byte ignored", ack, 0);
        bus_stop(); qwait();
        check(gc_count == 1, "R6 no extra reset pulse", gc_count, 1);

        // R10 read
        tx_q.push_back(8'hC3);
        tx_q.push_back(8'h5A);
        bus_start();
        put_byte({OWN, 1'b1}, ack);
        check(ack, "R7 read address ack", ack, 1);
        check(rx_is_read == 1'b1, "R7 read direction", rx_is_read, 1);
        get_byte(1'b1, rd);
        check(rd == 8'hC3, "R10 first read byte", rd, 8'hC3);
        get_byte(1'b0, rd);
        check(rd == 8'h5A, "R10 second read byte", rd, 8'h5A);
        qwait();
        check(sda_line == 1'b1, "R10 released after NACK", sda_line, 1);
        bus_stop(); qwait();
        check(stop_count == 8, "R11 stop pulse total", stop_count, 8);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule